// File: doc/BRIEF.md
# Synthesizer Channel Programming Sequencer

This block retunes a serially programmed PLL frequency synthesizer to a channel. A start strobe comes with a channel number. The block then issues a fixed burst of seven register writes, one after another. Each write is a 22-bit frame: an 18-bit data value followed by a 4-bit register address. Each frame goes to a downstream serial shifter through a go/sent handshake, and the next write does not begin until the current one has been reported sent. The shifter itself, clock generation for the serial link and the synthesizer are outside this block.

The only value that depends on the channel is the RF main (N) divider. It is an affine function of the channel, with one irregular channel that uses a fixed value. All other writes carry constants. Register addresses and constant bit positions are parameters, so the address map can change without touching the control logic. The block reports busy while a burst runs, pulses done at the end of a burst, and pulses an error when a start asks for a channel outside the legal range.

Top module: `chan_tune_seq`

## Requirements
- R1: `frame_o` carries the data value in bits 21:4 and the register address in bits 3:0. Bit 21 is the first bit the shifter sends.
- R2: A burst writes to these addresses, in this order: configuration (address 0), power-down (2), phase-detector gain (1), RF N divider (3), IF N divider (4), RF R divider (6), IF R divider (7).
- R3: The constant data values are: configuration 0x00040 (reference halving, bit 6), power-down 0x00003 (IF enable bit 1, RF enable bit 0), phase-detector gain 0, IF N divider 1496, and 44 for both R dividers.
- R4: The RF N divider data is 2033 + 5·channel. The exception is channel 14, which uses 2110.
- R5: Each frame is announced by a one-cycle `go_o` pulse, and `frame_o` only changes in a cycle where `go_o` is high.
  - The first `go_o` appears in the cycle after the clock edge that accepts `start_i`.
  - Each later `go_o` appears in the cycle after the edge that samples `sent_i` high.
- R6: Legal channels are 1 to 14. A start in idle with channel 0 or 15 gives a one-cycle `err_o` pulse in the next cycle. It issues no `go_o` and leaves `busy_o` low.
- R7: `busy_o` is high from the first `go_o` until the burst ends. Any start seen while busy is ignored, whatever its channel, and raises no error.
- R8: `done_o` pulses for one cycle in the cycle after the edge that samples `sent_i` for the seventh write. `busy_o` falls in that same cycle.
- R9: `sent_i` has no effect while the block is idle.
- R10: An asynchronous active-low `rst_n` clears `busy_o`, `done_o`, `err_o` and `go_o` at once and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to retune to `chan_i` |
| chan_i | input | 4 | Channel number |
| sent_i | input | 1 | Shifter reports the current frame fully sent |
| go_o | output | 1 | One-cycle pulse: `frame_o` is ready to send |
| frame_o | output | 22 | Data (21:4) and address (3:0) of the current write |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse: burst complete |
| err_o | output | 1 | One-cycle pulse: illegal channel requested |

## Verification
The sharpest collision is a new start request arriving on the same clock edge as the `sent_i` for the seventh write. That edge both ends the burst and is sampled while `busy_o` is still high.

The bench provokes this by taking the handshake under direct control and raising `start_i` with `sent_i` on that final edge. It then requires `done_o` high, `busy_o` low and no `go_o` in the next cycle, and no `go_o` in the cycles after that. The same idea is applied to an illegal-channel start in the middle of a burst, which must produce neither an error nor a change to the frames.

// File: rtl/chan_tune_pkg.sv
package chan_tune_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } tune_st_e;

    // Order of the writes in one burst; the encoding is the burst position.
    typedef enum logic [2:0] {
        W_CFG  = 3'd0,
        W_PWR  = 3'd1,
        W_PDG  = 3'd2,
        W_RFN  = 3'd3,
        W_IFN  = 3'd4,
        W_RFR  = 3'd5,
        W_IFR  = 3'd6
    } write_step_e;

    localparam write_step_e LAST_STEP = W_IFR;

endpackage

// File: rtl/chan_rfn_calc.sv
module chan_rfn_calc #(
    parameter int CHAN_W      = 4,
    parameter int DATA_W      = 18,
    parameter int CH_MIN      = 1,
    parameter int CH_MAX      = 14,
    parameter int RFN_BASE    = 2033,
    parameter int RFN_STEP    = 5,
    parameter int ODD_CH      = 14,
    parameter int ODD_RFN     = 2110
) (
    input  logic [CHAN_W-1:0] chan_i,
    output logic              legal_o,
    output logic [DATA_W-1:0] rf_n_o
);

    logic [DATA_W-1:0] affine_val;

    always_comb begin
        legal_o    = (chan_i >= CHAN_W'(CH_MIN)) && (chan_i <= CHAN_W'(CH_MAX));
        affine_val = DATA_W'(RFN_BASE) + DATA_W'(RFN_STEP) * DATA_W'(chan_i);
        if (chan_i == CHAN_W'(ODD_CH)) begin
            rf_n_o = DATA_W'(ODD_RFN);
        end else begin
            rf_n_o = affine_val;
        end
    end

endmodule

// File: rtl/chan_step_table.sv
module chan_step_table
    import chan_tune_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int ADDR_W   = 4,
    parameter int A_CFG    = 0,
    parameter int A_PWR    = 2,
    parameter int A_PDG    = 1,
    parameter int A_RFN    = 3,
    parameter int A_IFN    = 4,
    parameter int A_RFR    = 6,
    parameter int A_IFR    = 7,
    parameter int V_CFG    = 64,
    parameter int V_PWR    = 3,
    parameter int V_PDG    = 0,
    parameter int V_IFN    = 1496,
    parameter int V_RFR    = 44,
    parameter int V_IFR    = 44,
    localparam int FRAME_W = DATA_W + ADDR_W
) (
    input  write_step_e        step_i,
    input  logic [DATA_W-1:0]  rf_n_i,
    output logic [FRAME_W-1:0] frame_o
);

    logic [DATA_W-1:0] data_v;
    logic [ADDR_W-1:0] addr_v;

    always_comb begin
        data_v = '0;
        addr_v = '0;
        case (step_i)
            W_CFG: begin data_v = DATA_W'(V_CFG); addr_v = ADDR_W'(A_CFG); end
            W_PWR: begin data_v = DATA_W'(V_PWR); addr_v = ADDR_W'(A_PWR); end
            W_PDG: begin data_v = DATA_W'(V_PDG); addr_v = ADDR_W'(A_PDG); end
            W_RFN: begin data_v = rf_n_i;         addr_v = ADDR_W'(A_RFN); end
            W_IFN: begin data_v = DATA_W'(V_IFN); addr_v = ADDR_W'(A_IFN); end
            W_RFR: begin data_v = DATA_W'(V_RFR); addr_v = ADDR_W'(A_RFR); end
            W_IFR: begin data_v = DATA_W'(V_IFR); addr_v = ADDR_W'(A_IFR); end
            default: begin data_v = '0; addr_v = '0; end
        endcase
        frame_o = {data_v, addr_v};
    end

endmodule

// File: rtl/chan_tune_seq.sv
module chan_tune_seq
    import chan_tune_pkg::*;
#(
    parameter int CHAN_W    = 4,
    parameter int DATA_W    = 18,
    parameter int ADDR_W    = 4,
    parameter int CH_MIN    = 1,
    parameter int CH_MAX    = 14,
    parameter int RFN_BASE  = 2033,
    parameter int RFN_STEP  = 5,
    parameter int ODD_CH    = 14,
    parameter int ODD_RFN   = 2110,
    parameter int A_CFG     = 0,
    parameter int A_PWR     = 2,
    parameter int A_PDG     = 1,
    parameter int A_RFN     = 3,
    parameter int A_IFN     = 4,
    parameter int A_RFR     = 6,
    parameter int A_IFR     = 7,
    parameter int REFDIV2_BIT = 6,
    parameter int IF_EN_BIT   = 1,
    parameter int RF_EN_BIT   = 0,
    parameter int IFN_VAL   = 1496,
    parameter int RFR_VAL   = 44,
    parameter int IFR_VAL   = 44
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [CHAN_W-1:0]          chan_i,
    input  logic                       sent_i,
    output logic                       go_o,
    output logic [DATA_W+ADDR_W-1:0]   frame_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       err_o
);

    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int CFG_VAL = 1 << REFDIV2_BIT;
    localparam int PWR_VAL = (1 << IF_EN_BIT) | (1 << RF_EN_BIT);

    typedef struct packed {
        tune_st_e          state;
        write_step_e       step;
        logic [DATA_W-1:0] rf_n;
        logic [FRAME_W-1:0] frame;
        logic              go;
        logic              busy;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic               chan_legal;
    logic [DATA_W-1:0]  chan_rfn;
    write_step_e        tbl_step;
    logic [DATA_W-1:0]  tbl_rfn;
    logic [FRAME_W-1:0] tbl_frame;

    chan_rfn_calc #(
        .CHAN_W   (CHAN_W),
        .DATA_W   (DATA_W),
        .CH_MIN   (CH_MIN),
        .CH_MAX   (CH_MAX),
        .RFN_BASE (RFN_BASE),
        .RFN_STEP (RFN_STEP),
        .ODD_CH   (ODD_CH),
        .ODD_RFN  (ODD_RFN)
    ) u_calc (
        .chan_i  (chan_i),
        .legal_o (chan_legal),
        .rf_n_o  (chan_rfn)
    );

    // Table is addressed by the step about to be issued, never by seq_d.
    always_comb begin
        if (seq_q.state == ST_IDLE) begin
            tbl_step = W_CFG;
            tbl_rfn  = chan_rfn;
        end else begin
            tbl_step = write_step_e'(seq_q.step + 3'd1);
            tbl_rfn  = seq_q.rf_n;
        end
    end

    chan_step_table #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .A_CFG  (A_CFG),
        .A_PWR  (A_PWR),
        .A_PDG  (A_PDG),
        .A_RFN  (A_RFN),
        .A_IFN  (A_IFN),
        .A_RFR  (A_RFR),
        .A_IFR  (A_IFR),
        .V_CFG  (CFG_VAL),
        .V_PWR  (PWR_VAL),
        .V_PDG  (0),
        .V_IFN  (IFN_VAL),
        .V_RFR  (RFR_VAL),
        .V_IFR  (IFR_VAL)
    ) u_table (
        .step_i  (tbl_step),
        .rf_n_i  (tbl_rfn),
        .frame_o (tbl_frame)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.go   = 1'b0;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (chan_legal) begin
                        seq_d.state = ST_WAIT;
                        seq_d.step  = W_CFG;
                        seq_d.rf_n  = chan_rfn;
                        seq_d.frame = tbl_frame;
                        seq_d.go    = 1'b1;
                        seq_d.busy  = 1'b1;
                    end else begin
                        seq_d.err   = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (sent_i) begin
                    if (seq_q.step == LAST_STEP) begin
                        seq_d.state = ST_IDLE;
                        seq_d.busy  = 1'b0;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.step  = tbl_step;
                        seq_d.frame = tbl_frame;
                        seq_d.go    = 1'b1;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign go_o    = seq_q.go;
    assign frame_o = seq_q.frame;
    assign busy_o  = seq_q.busy;
    assign done_o  = seq_q.done;
    assign err_o   = seq_q.err;

endmodule

// File: rtl/chan_tune_seq_chk.sv
module chan_tune_seq_chk #(
    parameter int FRAME_W = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sent_i,
    input logic               go_o,
    input logic [FRAME_W-1:0] frame_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               err_o
);

    logic [3:0] go_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_cnt <= '0;
        end else if (done_o) begin
            go_cnt <= '0;
        end else if (go_o) begin
            go_cnt <= go_cnt + 4'd1;
        end
    end

    // R7
    go_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> busy_o);

    // R5
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && !sent_i) |=> !go_o);

    // R5
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_o |-> $stable(frame_o));

    // R8
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (go_cnt == 4'd7));

    // R8
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !go_o));

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_o, done_o, err_o}));

    // R9
    stray_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && sent_i) |=> !go_o);

endmodule

bind chan_tune_seq chan_tune_seq_chk #(.FRAME_W(DATA_W + ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sent_i  (sent_i),
    .go_o    (go_o),
    .frame_o (frame_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
);

// File: tb/sim_chan_tune_seq.sv
`timescale 1ns/1ps
module sim_chan_tune_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  chan_i = '0;
    logic        sent_i;
    logic        go_o, busy_o, done_o, err_o;
    logic [21:0] frame_o;

    logic        resp_sent = 1'b0;
    logic        stray_sent = 1'b0;
    logic        manual = 1'b0;
    logic        pend = 1'b0;
    int          dly = 0;
    int          ncap = 0;
    int          nerr = 0;
    logic [21:0] cap [0:15];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    assign sent_i = resp_sent | stray_sent;

    always #10 clk = ~clk;

    chan_tune_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .sent_i(sent_i), .go_o(go_o), .frame_o(frame_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    // Downstream writer model: records each frame, answers after a random delay.
    always @(negedge clk) begin
        cycles = cycles + 1;
        resp_sent = 1'b0;
        if (!rst_n) begin
            pend = 1'b0;
        end else begin
            if (err_o) nerr = nerr + 1;
            if (go_o) begin
                if (ncap < 16) cap[ncap] = frame_o;
                ncap = ncap + 1;
                pend = !manual;
                dly = $urandom % 5;
            end else if (pend) begin
                if (dly == 0) begin
                    resp_sent = 1'b1;
                    pend = 1'b0;
                end else begin
                    dly = dly - 1;
                end
            end
        end
    end

    function automatic logic [17:0] exp_rfn(int ch);
        if (ch == 14) return 18'd2110;
        return 18'(2033 + 5 * ch);
    endfunction

    function automatic logic [21:0] exp_frame(int idx, int ch);
        case (idx)
            0: return {18'h00040, 4'd0};
            1: return {18'h00003, 4'd2};
            2: return {18'd0, 4'd1};
            3: return {exp_rfn(ch), 4'd3};
            4: return {18'd1496, 4'd4};
            5: return {18'd44, 4'd6};
            default: return {18'd44, 4'd7};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Full retune with the model writer; disturb_ch >= 0 pulses a second start while busy.
    task automatic run_tune(input int ch, input int disturb_ch);
        int n;
        int e0;
        ncap = 0;
        e0 = nerr;
        @(negedge clk);
        start_i = 1'b1;
        chan_i = 4'(ch);
        @(negedge clk);
        start_i = 1'b0;
        check(go_o && busy_o, "R5", "first go one cycle after start", {30'd0, go_o, busy_o}, 32'h3);
        if (disturb_ch >= 0) begin
            @(negedge clk);
            start_i = 1'b1;
            chan_i = 4'(disturb_ch);
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!done_o && n < 300) begin
            @(negedge clk);
            n = n + 1;
        end
        check(done_o == 1'b1, "R8", "done seen", {31'd0, done_o}, 32'd1);
        check(busy_o == 1'b0, "R8", "busy low with done", {31'd0, busy_o}, 32'd0);
        check(ncap == 7, "R2", "frames per burst", ncap, 32'd7);
        for (int i = 0; i < 7; i++) begin
            check(cap[i] == exp_frame(i, ch), (i == 3) ? "R4" : "R3",
                  $sformatf("frame %0d ch %0d", i, ch), {10'd0, cap[i]}, {10'd0, exp_frame(i, ch)});
        end
        @(negedge clk);
        check(done_o == 1'b0 && go_o == 1'b0, "R8", "done single cycle, no further go",
              {30'd0, done_o, go_o}, 32'd0);
        if (disturb_ch >= 0) begin
            check(nerr == e0, "R7", "start while busy ignored", nerr - e0, 32'd0);
        end
    endtask

    task automatic run_illegal(input int ch);
        ncap = 0;
        @(negedge clk);
        start_i = 1'b1;
        chan_i = 4'(ch);
        @(negedge clk);
        start_i = 1'b0;
        check(err_o && !busy_o && !go_o, "R6", $sformatf("error pulse ch %0d", ch),
              {29'd0, err_o, busy_o, go_o}, 32'h4);
        @(negedge clk);
        check(err_o == 1'b0, "R6", "error single cycle", {31'd0, err_o}, 32'd0);
        repeat (3) @(negedge clk);
        check(ncap == 0 && !busy_o, "R6", "no write after illegal channel", ncap, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check({go_o, busy_o, done_o, err_o} == 4'b0, "R10", "reset state",
              {28'd0, go_o, busy_o, done_o, err_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 directed channels, including the irregular one and both ends
        run_tune(1, -1);
        run_tune(14, -1);
        run_tune(13, -1);
        check(cap[3][3:0] == 4'd3 && cap[3][21:4] == 18'd2098, "R1", "field positions ch13",
              {10'd0, cap[3]}, {10'd0, 18'd2098, 4'd3});

        // R6 illegal channels
        run_illegal(0);
        run_illegal(15);

        // R7 starts while busy: illegal one and legal one
        run_tune(6, 0);
        run_tune(9, 2);

        // R9 stray sent while idle
        ncap = 0;
        @(negedge clk);
        stray_sent = 1'b1;
        repeat (2) @(negedge clk);
        stray_sent = 1'b0;
        @(negedge clk);
        check(ncap == 0 && !busy_o && !done_o, "R9", "sent in idle ignored", ncap, 32'd0);

        // R7 R8: new start on the same edge as the final sent
        manual = 1'b1;
        ncap = 0;
        @(negedge clk);
        start_i = 1'b1;
        chan_i = 4'd7;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            stray_sent = 1'b1;
            if (k == 6) begin
                start_i = 1'b1;
                chan_i = 4'd5;
            end
            @(negedge clk);
            stray_sent = 1'b0;
            start_i = 1'b0;
            if (k < 6) begin
                check(go_o == 1'b1, "R5", $sformatf("go after sent %0d", k), {31'd0, go_o}, 32'd1);
            end else begin
                check(done_o && !busy_o && !go_o, "R8", "done with colliding start",
                      {29'd0, done_o, busy_o, go_o}, 32'h4);
            end
        end
        repeat (3) @(negedge clk);
        check(ncap == 7 && !busy_o, "R7", "colliding start ignored", ncap, 32'd7);
        manual = 1'b0;

        // R10 asynchronous reset mid-burst
        @(negedge clk);
        start_i = 1'b1;
        chan_i = 4'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        #3 rst_n = 1'b0;
        #1;
        check({go_o, busy_o, done_o, err_o} == 4'b0, "R10", "async clear mid-burst",
              {28'd0, go_o, busy_o, done_o, err_o}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ncap = 0;
        repeat (4) @(negedge clk);
        check(ncap == 0 && !busy_o, "R10", "idle after reset", ncap, 32'd0);

        // Random channels, legal and illegal
        for (int t = 0; t < 24; t++) begin
            int ch;
            ch = $urandom % 16;
            if (ch >= 1 && ch <= 14) run_tune(ch, -1);
            else run_illegal(ch);
        end

        finish_run();
    end

    initial begin
        while (cycles < 150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_run();
    end

endmodule